// File: doc/BRIEF.md
# Serial Controller Interrupt Identifier

This block ranks the interrupt causes of a 16550-style serial controller and reports the winner as an identification byte together with one active-high interrupt request line. The surrounding controller supplies the status it already keeps as plain inputs. These inputs are the line error bits, the data-ready flag, a character-timeout flag, the FIFO enable, fill count and trigger level, a holding-register-empty status and the modem delta bits. Register-access events arrive as single-cycle strobes: an enable-register write, a holding-register write and an identification-register read.

The block holds the 4-bit interrupt enable register and the sticky transmit-empty pending flag. Software re-arms that flag by writing the enable register while the holding register is empty. Writing the holding register clears it, and so does reading the identification byte while it shows the transmit-empty code. The identification byte and the request line are registered. Both reflect the inputs and strobes of the previous clock cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: When several sources are active, the identification reports the one with the highest priority. The order from highest to lowest is line error, character timeout, received data, transmit empty, modem status.
- R2: Bits [3:0] of the identification byte carry these codes: 0x6 for line error, 0xC for character timeout, 0x4 for received data, 0x2 for transmit empty, 0x0 for modem status, and 0x1 when no source is active.
- R3: The line error source is active when enable bit 2 is set and any bit of `lsr_err` is set. The bits of `lsr_err` are [3] break, [2] framing, [1] parity and [0] overrun.
- R4: The character-timeout source is active when `rx_timeout` is high and enable bit 0 is set. With bit 0 clear, the timeout is masked.
- R5: The received-data source needs enable bit 0 and `data_ready`. In addition, either `fifo_en` is low or `rx_count` is at least `rx_trig`.
- R6: An `iir_rd` strobe while bits [3:0] read 0x2 clears the transmit-empty pending flag. An `iir_rd` strobe while any other code is shown leaves the flag unchanged.
- R7: An `ier_wr` strobe while `thr_empty` is high sets the transmit-empty pending flag. That source then needs enable bit 1 to be reported.
- R8: A `thr_wr` strobe clears the transmit-empty pending flag. A clear takes precedence over a set in the same cycle.
- R9: Bits [7:6] of the identification byte are 11 when `fifo_en` is high and 00 when it is low. Bits [5:4] are always 0.
- R10: An enable-register write stores only `ier_wdata[3:0]`, and `ier_q` shows the stored value. Enable bit 3 gates the modem source, which is active when any `msr_delta` bit is set.
- R11: After reset, `iir` reads 0x01, `ier_q` reads 0 and `irq` is low.
- R12: `iir` and `irq` change at the first clock edge after an input or strobe changes. `irq` is high exactly when bits [3:0] are not 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| ier_wr | input | 1 | Enable-register write strobe |
| ier_wdata | input | 8 | Enable-register write data |
| thr_wr | input | 1 | Holding-register write strobe |
| iir_rd | input | 1 | Identification-register read strobe |
| thr_empty | input | 1 | Holding register (or transmit FIFO) empty |
| lsr_err | input | 4 | Break, framing, parity, overrun |
| data_ready | input | 1 | Receive data available |
| rx_timeout | input | 1 | Character timeout pending |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig | input | CW | Receive FIFO trigger level |
| msr_delta | input | 4 | Modem status change bits |
| ier_q | output | 4 | Stored interrupt enables |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every result is due one clock edge after its stimulus. This covers the identification byte, the request line and the stored enables, because the next-state logic already folds in the strobes of the same cycle. The bench drives inputs on the falling edge and samples on the following falling edge, so exactly one rising edge lies between a stimulus and its check. For the request-timing requirement, the bench also samples just after the driving edge and before the rising edge, to show that nothing changed early. Any pending transmit-empty flag is flushed with a holding-register write in a separate cycle before each vector.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 5;

  // source slots, index 0 is the highest priority
  localparam int S_LINE = 0;
  localparam int S_TMO  = 1;
  localparam int S_RXD  = 2;
  localparam int S_THR  = 3;
  localparam int S_MDM  = 4;

  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;
  localparam logic [3:0] ID_NONE = 4'h1;

  function automatic logic [3:0] slot_code(input int idx);
    case (idx)
      S_LINE:  slot_code = ID_LINE;
      S_TMO:   slot_code = ID_TMO;
      S_RXD:   slot_code = ID_RXD;
      S_THR:   slot_code = ID_THR;
      default: slot_code = ID_MDM;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_eval.sv
module irq_src_eval
  import uart_irq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [3:0]      ier,
  input  logic [3:0]      lsr_err,
  input  logic            data_ready,
  input  logic            rx_timeout,
  input  logic            fifo_en,
  input  logic [CW-1:0]   rx_count,
  input  logic [CW-1:0]   rx_trig,
  input  logic            thr_pend,
  input  logic [3:0]      msr_delta,
  output logic [NSRC-1:0] src
);

  logic rx_level_ok;

  always_comb begin
    rx_level_ok  = !fifo_en || (rx_count >= rx_trig);
    src          = '0;
    src[S_LINE]  = ier[2] && (|lsr_err);
    src[S_TMO]   = ier[0] && rx_timeout;
    src[S_RXD]   = ier[0] && data_ready && rx_level_ok;
    src[S_THR]   = ier[1] && thr_pend;
    src[S_MDM]   = ier[3] && (|msr_delta);
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] src,
  output logic [3:0]      id,
  output logic            any
);

  logic [NSRC:0]   seen;
  logic [NSRC-1:0] hit;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign hit[g]    = src[g] && !seen[g];
    assign seen[g+1] = seen[g] || src[g];
  end

  assign any = seen[NSRC];

  always_comb begin
    id = ID_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (hit[i]) id = slot_code(i);
    end
  end

  // R1: at most one winner
  always_comb begin
    a_one_winner_r1: assert ($onehot0(hit));
  end

endmodule

// File: rtl/thr_pend_ctl.sv
module thr_pend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ier_wr,
  input  logic thr_wr,
  input  logic iir_rd,
  input  logic iir_is_thr,
  input  logic thr_empty,
  output logic pend_q,
  output logic pend_nxt
);

  logic clr, set;

  always_comb begin
    clr      = thr_wr || (iir_rd && iir_is_thr);
    set      = ier_wr && thr_empty;
    pend_nxt = pend_q;
    if (clr)      pend_nxt = 1'b0;
    else if (set) pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= 1'b0;
    else if (clr || set) pend_q <= pend_nxt;
  end

  p_thr_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !pend_q);

  p_iir_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_is_thr) |=> !pend_q);

  p_ier_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thr_empty && !thr_wr && !(iir_rd && iir_is_thr)) |=> pend_q);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ier_wr,
  input  logic [7:0]    ier_wdata,
  input  logic          thr_wr,
  input  logic          iir_rd,
  input  logic          thr_empty,
  input  logic [3:0]    lsr_err,
  input  logic          data_ready,
  input  logic          rx_timeout,
  input  logic          fifo_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  input  logic [3:0]    msr_delta,
  output logic [3:0]    ier_q,
  output logic [7:0]    iir,
  output logic          irq
);

  logic [3:0]      ier_nxt;
  logic            pend_q, pend_nxt;
  logic [NSRC-1:0] src;
  logic [3:0]      id_nxt;
  logic            any_nxt;
  logic [7:0]      iir_nxt;

  always_comb begin
    ier_nxt = ier_wr ? ier_wdata[3:0] : ier_q;
  end

  thr_pend_ctl u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .ier_wr     (ier_wr),
    .thr_wr     (thr_wr),
    .iir_rd     (iir_rd),
    .iir_is_thr (iir[3:0] == ID_THR),
    .thr_empty  (thr_empty),
    .pend_q     (pend_q),
    .pend_nxt   (pend_nxt)
  );

  irq_src_eval #(.CW(CW)) u_src (
    .ier        (ier_nxt),
    .lsr_err    (lsr_err),
    .data_ready (data_ready),
    .rx_timeout (rx_timeout),
    .fifo_en    (fifo_en),
    .rx_count   (rx_count),
    .rx_trig    (rx_trig),
    .thr_pend   (pend_nxt),
    .msr_delta  (msr_delta),
    .src        (src)
  );

  irq_prio_enc u_enc (
    .src (src),
    .id  (id_nxt),
    .any (any_nxt)
  );

  always_comb begin
    iir_nxt = {{2{fifo_en}}, 2'b00, id_nxt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= 4'h0;
    else if (ier_wr) ier_q <= ier_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir <= {4'h0, ID_NONE};
      irq <= 1'b0;
    end else begin
      iir <= iir_nxt;
      irq <= any_nxt;
    end
  end

  p_irq_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir[3:0] != ID_NONE));

  p_fifo_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |=> (iir[7:4] == 4'b1100));

  p_fifo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (iir[7:4] == 4'b0000));

  p_ier_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ({4'h0, ier_q} == ($past(ier_wdata) & 8'h0F)));

  p_line_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_nxt[2] && (|lsr_err)) |=> (iir[3:0] == ID_LINE));

  p_ier_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_wr |=> $stable(ier_q));

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ier_wr, thr_wr, iir_rd, thr_empty;
  logic [7:0]    ier_wdata;
  logic [3:0]    lsr_err, msr_delta;
  logic          data_ready, rx_timeout, fifo_en;
  logic [CW-1:0] rx_count, rx_trig;
  logic [3:0]    ier_q;
  logic [7:0]    iir;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .thr_empty(thr_empty),
    .lsr_err(lsr_err), .data_ready(data_ready), .rx_timeout(rx_timeout),
    .fifo_en(fifo_en), .rx_count(rx_count), .rx_trig(rx_trig),
    .msr_delta(msr_delta), .ier_q(ier_q), .iir(iir), .irq(irq)
  );

  // row: ier[27:24] mask[23:19] fifo[18] cnt[17:13] trig[12:8] exp[7:0]
  // mask bits: 4 line, 3 timeout, 2 rx data, 1 tx empty, 0 modem
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {4'hF, 5'b00000, 1'b0, 5'd0,  5'd0,  8'h01},
    {4'hF, 5'b10000, 1'b0, 5'd0,  5'd0,  8'h06},
    {4'h4, 5'b10000, 1'b0, 5'd0,  5'd0,  8'h06},
    {4'hB, 5'b10000, 1'b0, 5'd0,  5'd0,  8'h01},
    {4'h1, 5'b01000, 1'b0, 5'd0,  5'd0,  8'h0C},
    {4'hE, 5'b01000, 1'b0, 5'd0,  5'd0,  8'h01},
    {4'h1, 5'b00100, 1'b0, 5'd0,  5'd0,  8'h04},
    {4'h1, 5'b00100, 1'b1, 5'd3,  5'd4,  8'hC1},
    {4'h1, 5'b00100, 1'b1, 5'd4,  5'd4,  8'hC4},
    {4'h1, 5'b00100, 1'b1, 5'd14, 5'd14, 8'hC4},
    {4'h2, 5'b00010, 1'b0, 5'd0,  5'd0,  8'h02},
    {4'hD, 5'b00010, 1'b0, 5'd0,  5'd0,  8'h01},
    {4'h8, 5'b00001, 1'b0, 5'd0,  5'd0,  8'h00},
    {4'h7, 5'b00001, 1'b0, 5'd0,  5'd0,  8'h01},
    {4'hF, 5'b11111, 1'b0, 5'd0,  5'd0,  8'h06},
    {4'hF, 5'b00011, 1'b0, 5'd0,  5'd0,  8'h02}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ier_wr = 0; thr_wr = 0; iir_rd = 0; thr_empty = 0; ier_wdata = 0;
    lsr_err = 0; msr_delta = 0; data_ready = 0; rx_timeout = 0;
    fifo_en = 0; rx_count = 0; rx_trig = 0;
  endtask

  // flush pending flag, then write enables with the sources applied;
  // returns sampled on the falling edge after the write edge
  task automatic apply(input logic [3:0] ien, input logic [4:0] mask,
                       input logic [3:0] err, input logic fen,
                       input logic [CW-1:0] cnt, input logic [CW-1:0] trg);
    @(negedge clk);
    idle_inputs();
    thr_wr = 1;
    @(negedge clk);
    thr_wr     = 0;
    lsr_err    = mask[4] ? err : 4'h0;
    rx_timeout = mask[3];
    data_ready = mask[2];
    thr_empty  = mask[1];
    msr_delta  = mask[0] ? 4'b0100 : 4'h0;
    fifo_en    = fen;
    rx_count   = cnt;
    rx_trig    = trg;
    ier_wdata  = {4'h0, ien};
    ier_wr     = 1;
    @(negedge clk);
    ier_wr = 0;
  endtask

  function automatic logic [3:0] model(input logic [4:0] mask);
    logic [3:0] r = 4'h1;
    if (mask[0]) r = 4'h0;
    if (mask[1]) r = 4'h2;
    if (mask[2]) r = 4'h4;
    if (mask[3]) r = 4'hC;
    if (mask[4]) r = 4'h6;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 iir", iir, 8'h01);
    check("R11 ier", {4'h0, ier_q}, 8'h00);
    check("R11 irq", {7'h0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R11 iir after release", iir, 8'h01);

    // table walk: R1 R2 R3 R4 R5 R7 R9 R10
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][27:24], VEC[v][23:19], 4'b0001, VEC[v][18],
            VEC[v][17:13], VEC[v][12:8]);
      check($sformatf("R2 R5 vector %0d", v), iir, VEC[v][7:0]);
      check($sformatf("R12 irq vector %0d", v), {7'h0, irq},
            {7'h0, VEC[v][3:0] != 4'h1});
    end

    // R1: every combination of sources with all enables
    for (int m = 0; m < 32; m++) begin
      apply(4'hF, m[4:0], 4'b1000, 1'b0, '0, '0);
      check($sformatf("R1 mask %0d", m), iir, {4'h0, model(m[4:0])});
    end

    // R3: each error bit alone
    for (int b = 0; b < 4; b++) begin
      apply(4'h4, 5'b10000, 4'b0001 << b, 1'b0, '0, '0);
      check($sformatf("R3 err bit %0d", b), iir, 8'h06);
    end

    // R10: upper write bits dropped
    @(negedge clk);
    idle_inputs();
    ier_wdata = 8'hF5; ier_wr = 1;
    @(negedge clk);
    ier_wr = 0;
    check("R10 ier low nibble", {4'h0, ier_q}, 8'h05);

    // R6: read while code 2 clears pending
    apply(4'h2, 5'b00010, 4'h0, 1'b0, '0, '0);
    check("R6 setup", iir, 8'h02);
    thr_empty = 0;
    iir_rd = 1;
    @(negedge clk);
    iir_rd = 0;
    check("R6 cleared by read", iir, 8'h01);

    // R6: read while another code shows keeps pending
    apply(4'h6, 5'b10010, 4'b0010, 1'b0, '0, '0);
    check("R6 line shown", iir, 8'h06);
    thr_empty = 0;
    iir_rd = 1;
    @(negedge clk);
    iir_rd  = 0;
    lsr_err = 0;
    @(negedge clk);
    check("R6 pending kept", iir, 8'h02);

    // R8: holding write clears pending
    thr_wr = 1;
    @(negedge clk);
    thr_wr = 0;
    check("R8 cleared by write", iir, 8'h01);

    // R8: clear wins over a same-cycle set
    thr_empty = 1; ier_wdata = 8'h02; ier_wr = 1; thr_wr = 1;
    @(negedge clk);
    ier_wr = 0; thr_wr = 0;
    check("R8 clear over set", iir, 8'h01);

    // R7: set with empty, but bit1 off hides it until enabled
    ier_wdata = 8'h00; ier_wr = 1;
    @(negedge clk);
    ier_wr = 0;
    check("R7 hidden", iir, 8'h01);
    thr_empty = 0;
    ier_wdata = 8'h02; ier_wr = 1;
    @(negedge clk);
    ier_wr = 0;
    check("R7 pending from earlier write", iir, 8'h02);

    // R12: modem delta, no change before the edge, change after it
    @(negedge clk);
    idle_inputs();
    thr_wr = 1; ier_wdata = 8'h08; ier_wr = 1;
    @(negedge clk);
    thr_wr = 0; ier_wr = 0;
    check("R12 quiet", {7'h0, irq}, 8'h00);
    msr_delta = 4'b0001;
    #1;
    check("R12 not before edge", {7'h0, irq}, 8'h00);
    @(negedge clk);
    check("R12 irq after edge", {7'h0, irq}, 8'h01);
    check("R10 modem code", iir, 8'h00);

    // R9: fifo bits follow fifo_en
    fifo_en = 1;
    @(negedge clk);
    check("R9 fifo on", iir, 8'hC0);
    fifo_en = 0;
    @(negedge clk);
    check("R9 fifo off", iir, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule